// File: doc/BRIEF.md
# Prescaled Start/Stop Interval Timer

This block is a memory-mapped down-counting timer for a small processor bus that uses a chip select, a write enable, a word address and 32-bit read and write data. Software first writes two load values: a prescale reload and a main count. It then sets a start bit in the control word and polls the status word until the running flag drops. While the timer runs, the prescale counter steps down once per clock. Each time it passes zero it reloads and takes one step off the main counter. When the main counter is found at zero, the timer halts by itself.

Start is honoured only while the timer is idle, and stop only while it runs. Both load registers refuse writes while the timer runs, so the configuration cannot change in the middle of an interval. Reading the count word returns the live counter while the timer runs and the stored load value while it is idle. Every access completes in the cycle it is presented.

Top module: `pscl_timer`

## Requirements
- R1: After a synchronous active-high reset, the status running bit (offset 0x1, bit 0) reads 0, and both the prescale register (offset 0x2) and the count register (offset 0x3) read 0.
- R2: `ready` is 1 in every cycle where `cs` is 1, for reads and writes alike. It is 0 when `cs` is 0. Read data is valid in the same cycle.
- R3: A write to the control word (offset 0x0) with bit 0 (start) set while idle loads both counters from the load registers and sets the running bit from the next cycle. This applies even when bit 1 is also set.
- R4: A start write while the timer runs has no effect, and the live count is not reloaded.
- R5: A control write with bit 1 (stop) set while the timer runs clears the running bit from the next cycle. This applies even when bit 0 is also set. A stop write while idle has no effect.
- R6: Writes to the prescale register or the count register while the timer runs are ignored. The stored values are unchanged when read back after the timer stops.
- R7: Reading the count register returns the live main counter while running, and the stored load value while idle.
- R8: While running with prescale value P, the main counter decreases by exactly one every P+1 cycles. The first decrement comes P+1 cycles after the start write is taken.
- R9: When the running main counter is at zero, the running bit clears on the next cycle. With count N and prescale P, the running bit is 1 for exactly N*(P+1)+1 cycles after the start write.
- R10: The control word, the upper 31 bits of the status word and every address other than 0x1, 0x2 and 0x3 read as zero. Writes to unmapped addresses change nothing.
- R11: Starting with a count load value of 0 keeps the running bit set for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select; one access per cycle while high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (8) | Word address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid in the cycle of the access |
| ready | output | 1 | Access acknowledge, same cycle as `cs` |

## Verification
The hardest situation to reach from the ports is a request that arrives while the timer is in the opposite state, placed so that the wrong outcome would be visible. A start write while running is only informative once the live count has already moved below its load value. The bench therefore polls the status word for exactly as many cycles as one prescale period takes, then issues the second start, and reads the count on the following cycle, where a reload and a correct ignore give different values. The expiry boundary is reached by polling status once per cycle and counting the high samples against N*(P+1)+1. The zero-count case is covered the same way.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  // Word offsets of the register window; software depends on them.
  localparam int unsigned OFS_CTRL   = 0;
  localparam int unsigned OFS_STATUS = 1;
  localparam int unsigned OFS_PSC    = 2;
  localparam int unsigned OFS_COUNT  = 3;

  // Control and status bit positions.
  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;
  localparam int unsigned STAT_RUN_BIT   = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STATUS,
    SEL_PSC,
    SEL_COUNT
  } reg_sel_e;
endpackage

// File: rtl/pscl_timer_regfile.sv
module pscl_timer_regfile
  import pscl_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PSC_W  = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              start_req,
  output logic              stop_req,
  output logic [PSC_W-1:0]  psc_init,
  output logic [CNT_W-1:0]  cnt_init
);

  reg_sel_e sel;
  logic     wr_en;

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
    if (addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    if (addr == ADDR_W'(OFS_PSC))    sel = SEL_PSC;
    if (addr == ADDR_W'(OFS_COUNT))  sel = SEL_COUNT;
  end

  assign wr_en     = cs && we;
  assign ready     = cs;
  assign start_req = wr_en && (sel == SEL_CTRL) && wdata[CTRL_START_BIT];
  assign stop_req  = wr_en && (sel == SEL_CTRL) && wdata[CTRL_STOP_BIT];

  // Load registers: protected while the timer runs.
  always_ff @(posedge clk) begin
    if (rst) begin
      psc_init <= '0;
      cnt_init <= '0;
    end else if (wr_en && !running) begin
      if (sel == SEL_PSC)   psc_init <= wdata[PSC_W-1:0];
      if (sel == SEL_COUNT) cnt_init <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (cs && !we) begin
      unique case (sel)
        SEL_STATUS: rdata[STAT_RUN_BIT] = running;
        SEL_PSC:    rdata = DATA_W'(psc_init);
        SEL_COUNT:  rdata = running ? DATA_W'(cnt_live) : DATA_W'(cnt_init);
        default:    rdata = '0;
      endcase
    end
  end

  AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(running) |-> ($stable(psc_init) && $stable(cnt_init))); // R6

endmodule

// File: rtl/pscl_timer_ctrl.sv
module pscl_timer_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic stop_req,
  input  logic expire,
  output logic running,
  output logic load
);

  logic start_ok;
  logic stop_ok;

  assign start_ok = start_req && !running;
  assign stop_ok  = stop_req && running;
  assign load     = start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (start_ok) begin
      running <= 1'b1;
    end else if (stop_ok || expire) begin
      running <= 1'b0;
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(start_req)); // R3

  AST_HALT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(stop_req || expire)); // R5

endmodule

// File: rtl/pscl_timer_count.sv
module pscl_timer_count #(
  parameter int unsigned PSC_W = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             running,
  input  logic [PSC_W-1:0] psc_init,
  input  logic [CNT_W-1:0] cnt_init,
  output logic [CNT_W-1:0] cnt_live,
  output logic             expire
);

  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             psc_wrap;
  logic             cnt_zero;

  assign psc_wrap = (psc_q == '0);
  assign cnt_zero = (cnt_q == '0);
  assign expire   = running && cnt_zero;
  assign cnt_live = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      psc_q <= psc_init;
      cnt_q <= cnt_init;
    end else if (running && !cnt_zero) begin
      if (psc_wrap) begin
        psc_q <= psc_init;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        psc_q <= psc_q - 1'b1;
      end
    end
  end

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && (cnt_q != $past(cnt_q)))
      |-> (cnt_q == $past(cnt_q) - 1'b1)); // R8

  AST_PSC_BOUND: assert property (@(posedge clk) disable iff (rst)
    running |-> (psc_q <= psc_init)); // R8

endmodule

// File: rtl/pscl_timer.sv
module pscl_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PSC_W  = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);

  logic             running;
  logic             load;
  logic             expire;
  logic             start_req;
  logic             stop_req;
  logic [PSC_W-1:0] psc_init;
  logic [CNT_W-1:0] cnt_init;
  logic [CNT_W-1:0] cnt_live;

  pscl_timer_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PSC_W(PSC_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .running(running), .cnt_live(cnt_live),
    .rdata(rdata), .ready(ready),
    .start_req(start_req), .stop_req(stop_req),
    .psc_init(psc_init), .cnt_init(cnt_init)
  );

  pscl_timer_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .start_req(start_req), .stop_req(stop_req), .expire(expire),
    .running(running), .load(load)
  );

  pscl_timer_count #(
    .PSC_W(PSC_W), .CNT_W(CNT_W)
  ) u_count (
    .clk(clk), .rst(rst), .load(load), .running(running),
    .psc_init(psc_init), .cnt_init(cnt_init),
    .cnt_live(cnt_live), .expire(expire)
  );

  AST_ZERO_HALTS: assert property (@(posedge clk) disable iff (rst)
    (running && (cnt_live == '0) && !load) |=> !running); // R9

  AST_READY_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (!cs) |-> (rdata == '0)); // R2

endmodule

// File: tb/pscl_timer_bench.sv
module pscl_timer_bench;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs  = 1'b0;
  logic          we  = 1'b0;
  logic [AW-1:0] addr  = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ready;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  pscl_timer u_pscl_timer (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic r);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata; r = ready;
    @(posedge clk); #1;
    cs = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    logic r;
    bus_read(a, d, r);
  endtask

  // Polls status once per cycle, returns number of samples with running=1.
  task automatic run_length(output int ones);
    logic [DW-1:0] v;
    ones = 0;
    for (int i = 0; i < 200; i++) begin
      rd(8'h1, v);
      if (v[0]) ones++;
      else break;
    end
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rd(8'h1, v); check("R1 status after reset", v, 32'h0);
    rd(8'h2, v); check("R1 prescale after reset", v, 32'h0);
    rd(8'h3, v); check("R1 count after reset", v, 32'h0);
  endtask

  task automatic t_ready;
    logic [DW-1:0] v;
    logic r;
    bus_read(8'h2, v, r); check("R2 ready on read", {31'h0, r}, 32'h1);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = 8'h40; wdata = 32'h0; #1;
    check("R2 ready on write", {31'h0, ready}, 32'h1);
    @(posedge clk); #1; cs = 1'b0; we = 1'b0;
    @(negedge clk); #1;
    check("R2 ready idle", {31'h0, ready}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [DW-1:0] v;
    bus_write(8'h2, 32'h0000_0011);
    bus_write(8'h3, 32'h0000_0022);
    bus_write(8'h7, 32'hFFFF_FFFF);
    bus_write(8'hFF, 32'hFFFF_FFFF);
    rd(8'h0, v);  check("R10 ctrl reads zero", v, 32'h0);
    rd(8'h7, v);  check("R10 addr 0x07 zero", v, 32'h0);
    rd(8'hFF, v); check("R10 addr 0xFF zero", v, 32'h0);
    rd(8'h2, v);  check("R10 prescale untouched", v, 32'h11);
    rd(8'h3, v);  check("R10 count untouched", v, 32'h22);
    rd(8'h1, v);  check("R10 status idle", v, 32'h0);
  endtask

  task automatic t_expiry;
    int n;
    bus_write(8'h2, 32'd2);
    bus_write(8'h3, 32'd3);
    bus_write(8'h0, 32'h1);
    run_length(n);
    check("R9 running cycles N*(P+1)+1", n, 32'd10);
  endtask

  task automatic t_zero_count;
    int n;
    logic [DW-1:0] v;
    bus_write(8'h2, 32'd5);
    bus_write(8'h3, 32'd0);
    bus_write(8'h0, 32'h1);
    run_length(n);
    check("R11 zero count one cycle", n, 32'd1);
    rd(8'h3, v); check("R7 idle count reads load value", v, 32'd0);
  endtask

  task automatic t_prescale;
    logic [DW-1:0] s [9];
    bus_write(8'h2, 32'd3);
    bus_write(8'h3, 32'd5);
    bus_write(8'h0, 32'h1);
    for (int i = 0; i < 9; i++) rd(8'h3, s[i]);
    check("R8 live count before first step", s[0], 32'd5);
    check("R8 live count last cycle of period", s[3], 32'd5);
    check("R8 first decrement after P+1", s[4], 32'd4);
    check("R8 second decrement", s[8], 32'd3);
    bus_write(8'h0, 32'h2);
  endtask

  task automatic t_protect_and_restart;
    logic [DW-1:0] v;
    bus_write(8'h2, 32'd3);
    bus_write(8'h3, 32'd100);
    bus_write(8'h0, 32'h1);
    for (int i = 0; i < 4; i++) rd(8'h1, v);
    bus_write(8'h0, 32'h1);
    rd(8'h3, v); check("R4 start while running no reload", v, 32'd99);
    check("R7 live count while running", v, 32'd99);
    bus_write(8'h2, 32'd7);
    bus_write(8'h3, 32'd9);
    rd(8'h1, v); check("R4 still running", v, 32'h1);
    bus_write(8'h0, 32'h2);
    rd(8'h1, v); check("R5 stop clears running", v, 32'h0);
    rd(8'h2, v); check("R6 prescale write ignored", v, 32'd3);
    rd(8'h3, v); check("R6 count write ignored", v, 32'd100);
  endtask

  task automatic t_both_bits;
    logic [DW-1:0] v;
    bus_write(8'h3, 32'd50);
    bus_write(8'h0, 32'h2);
    rd(8'h1, v); check("R5 stop while idle no effect", v, 32'h0);
    rd(8'h3, v); check("R5 count after idle stop", v, 32'd50);
    bus_write(8'h0, 32'h3);
    rd(8'h1, v); check("R3 start+stop while idle starts", v, 32'h1);
    bus_write(8'h0, 32'h3);
    rd(8'h1, v); check("R5 start+stop while running stops", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_ready();
    t_unmapped();
    t_expiry();
    t_zero_count();
    t_prescale();
    t_protect_and_restart();
    t_both_bits();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule